// File: doc/BRIEF.md
# One-Time Write Protection Controller

This block sits beside the serial framing logic of a 256-byte nonvolatile store and decides two things for every transaction. The first is whether a data byte aimed at the array may be committed. The second is whether the control byte that opened the frame is acknowledged. Two protection sources combine here. The first is an external lock pin: when it is high, the whole array refuses writes. The second is a one-way software flag: once set, it guards only the lower half of the array.

The flag is set by a complete write frame that carries the guard control code and ends with a stop condition, provided the lock pin is low at that stop. It can never be cleared by logic. Host software learns the state of the flag from the acknowledge: a frame that carries the guard code is acknowledged only while the flag is still clear. The framer keeps acknowledging blocked array writes and still runs its full busy time for them, so `ack_en` does not depend on the protection decision.

The flag models a nonvolatile bit. Its power-up value comes from a parameter, and the block reset does not touch it.

Top module: `wpc_top`

## Requirements
- R1: While `rst_n` is low, `commit_en` and `ack_en` are 0 whatever the other inputs are.
- R2: With `prot_pin` high, `commit_en` is 0 for every address, whatever the state of the flag.
- R3: With `prot_pin` low and the flag set, an array write (code 1010, `rd_sel`=0) gives `commit_en`=0 for addresses 00h–7Fh and `commit_en`=1 for addresses 80h–FFh.
- R4: With `prot_pin` low and the flag clear, an array write gives `commit_en`=1 at every address.
- R5: `commit_en` is 0 for reads (`rd_sel`=1) and for every control code other than 1010, including the guard code 0110.
- R6: A frame with code 1010 gives `ack_en`=1 for reads and writes, whatever the state of `prot_pin` and the flag. This includes writes that are blocked.
- R7: A frame with code 0110 gives `ack_en`=1 while the flag is clear and `ack_en`=0 once it is set, for reads and writes alike. Any code other than 1010 and 0110 gives `ack_en`=0.
- R8: If `prog_strobe` is high while code 0110, `rd_sel`=0 and `prot_pin`=0 are present, `guard_set` reads 1 from the next clock cycle on. The value of `tgt_addr` has no effect on this.
- R9: The flag stays clear in each of these cases: a 0110 write that ends with `prot_pin` high, a 0110 read, an array write, and a frame with no `prog_strobe` (an aborted frame).
- R10: Once `guard_set` is 1 it never returns to 0. An assertion of `rst_n` leaves it unchanged, and its power-up value is set by the `GUARD_INIT` parameter (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; gates the decisions but does not touch the flag |
| prot_pin | input | 1 | External lock pin level; high blocks every array write |
| ctrl_code | input | 4 | Decoded upper control-byte code of the current frame |
| rd_sel | input | 1 | Read/write bit of the control byte (1 = read) |
| tgt_addr | input | 8 | Target byte address of the current write |
| prog_strobe | input | 1 | One-cycle pulse: a valid stop ended a complete write frame |
| commit_en | output | 1 | The current array byte may be written |
| ack_en | output | 1 | The control byte is to be acknowledged |
| guard_set | output | 1 | State of the one-way lower-half protection flag |

## Verification
The bench sweeps the address around the 7Fh/80h boundary under every combination of pin and flag. A decoder that used the wrong address bit, or the wrong side of that bit, would commit writes into the guarded half or refuse writes to the open half. It also tries every case that must not set the flag: the pin high at the stop, a read, an array write, and a frame with no stop strobe. A design that ignored any one of these conditions would lock the lower half too early. Finally, it pulses reset after the flag is set and checks that the flag survives and that the guard code is then refused. A volatile flag would re-open the lower half, and an acknowledge that ignored the flag would hide the protection state from the host.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_ARRAY = 2'd1,
      ACC_GUARD = 2'd2
   } acc_kind_t;

endpackage

// File: rtl/wpc_code_dec.sv
module wpc_code_dec
   import wpc_pkg::*;
#(
   parameter int                CODE_W     = 4,
   parameter logic [CODE_W-1:0] ARRAY_CODE = 4'b1010,
   parameter logic [CODE_W-1:0] GUARD_CODE = 4'b0110
) (
   input  logic [CODE_W-1:0] code,
   output acc_kind_t         kind
);

   generate
      if (CODE_W < 1) begin : g_bad_width
         $error("wpc_code_dec: CODE_W must be at least 1");
      end
      if (ARRAY_CODE == GUARD_CODE) begin : g_bad_codes
         $error("wpc_code_dec: array and guard codes must differ");
      end
   endgenerate

   always_comb begin
      if (code == ARRAY_CODE)      kind = ACC_ARRAY;
      else if (code == GUARD_CODE) kind = ACC_GUARD;
      else                         kind = ACC_NONE;
   end

endmodule

// File: rtl/wpc_region_dec.sv
module wpc_region_dec #(
   parameter int ADDR_W    = 8,
   parameter bit GUARD_LOW = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_guard
);

   localparam int MSB = ADDR_W - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("wpc_region_dec: ADDR_W must be at least 2");
      end
      if (GUARD_LOW) begin : g_low_half
         assign in_guard = ~addr[MSB];
      end else begin : g_high_half
         assign in_guard = addr[MSB];
      end
   endgenerate

endmodule

// File: rtl/wpc_sticky_flag.sv
module wpc_sticky_flag #(
   parameter bit INIT = 1'b0
) (
   input  logic clk,
   input  logic set_req,
   output logic q
);

   logic q_r = INIT;

   always_ff @(posedge clk) begin
      if (set_req) q_r <= 1'b1;
   end

   assign q = q_r;

endmodule

// File: rtl/wpc_top.sv
module wpc_top
   import wpc_pkg::*;
#(
   parameter int                CODE_W     = 4,
   parameter int                ADDR_W     = 8,
   parameter logic [CODE_W-1:0] ARRAY_CODE = 4'b1010,
   parameter logic [CODE_W-1:0] GUARD_CODE = 4'b0110,
   parameter bit                GUARD_LOW  = 1'b1,
   parameter bit                GUARD_INIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_pin,
   input  logic [CODE_W-1:0] ctrl_code,
   input  logic              rd_sel,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              prog_strobe,
   output logic              commit_en,
   output logic              ack_en,
   output logic              guard_set
);

   localparam int                HALF     = 1 << (ADDR_W - 1);
   localparam logic [ADDR_W-1:0] HALF_VEC = ADDR_W'(HALF);

   acc_kind_t kind;
   logic      in_guard;
   logic      flag;
   logic      set_req;
   logic      is_arr;
   logic      is_grd;

   wpc_code_dec #(
      .CODE_W     (CODE_W),
      .ARRAY_CODE (ARRAY_CODE),
      .GUARD_CODE (GUARD_CODE)
   ) u_code (
      .code (ctrl_code),
      .kind (kind)
   );

   wpc_region_dec #(
      .ADDR_W    (ADDR_W),
      .GUARD_LOW (GUARD_LOW)
   ) u_region (
      .addr     (tgt_addr),
      .in_guard (in_guard)
   );

   wpc_sticky_flag #(
      .INIT (GUARD_INIT)
   ) u_flag (
      .clk     (clk),
      .set_req (set_req),
      .q       (flag)
   );

   assign is_arr = (kind == ACC_ARRAY);
   assign is_grd = (kind == ACC_GUARD);

   always_comb begin
      commit_en = rst_n & is_arr & ~rd_sel & ~prot_pin & ~(flag & in_guard);
      ack_en    = rst_n & (is_arr | (is_grd & ~flag));
      set_req   = rst_n & prog_strobe & is_grd & ~rd_sel & ~prot_pin & ~flag;
   end

   assign guard_set = flag;

   // R2: the lock pin overrides everything
   a_r2_pin_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      prot_pin |-> !commit_en);

   // R3: guarded lower half refused once the flag is set
   a_r3_low_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_set && GUARD_LOW && tgt_addr < HALF_VEC) |-> !commit_en);

   // R6: array frames always acknowledged
   a_r6_array_acked: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_code == ARRAY_CODE) |-> ack_en);

   // R7: guard code refused once the flag is set
   a_r7_guard_nack: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_set && ctrl_code == GUARD_CODE) |-> !ack_en);

   // R8: a qualifying program strobe sets the flag on the next cycle
   a_r8_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_strobe && ctrl_code == GUARD_CODE && !rd_sel && !prot_pin) |=> guard_set);

   // R9: without a qualifying strobe the flag stays clear
   a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!guard_set && !(prog_strobe && ctrl_code == GUARD_CODE && !rd_sel && !prot_pin))
      |=> !guard_set);

   // R10: the flag never falls
   a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      guard_set |=> guard_set);

endmodule

// File: tb/wpc_top_tb.sv
`timescale 1ns/100ps
module wpc_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prot_pin = 1'b0;
   logic [3:0] ctrl_code = 4'h0;
   logic       rd_sel = 1'b0;
   logic [7:0] tgt_addr = 8'h00;
   logic       prog_strobe = 1'b0;
   logic       commit_en;
   logic       ack_en;
   logic       guard_set;

   int total = 0;
   int bad = 0;
   bit mflag = 1'b0;   // reference model of the protection flag

   always #2.5 clk = ~clk;

   wpc_top dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .prot_pin    (prot_pin),
      .ctrl_code   (ctrl_code),
      .rd_sel      (rd_sel),
      .tgt_addr    (tgt_addr),
      .prog_strobe (prog_strobe),
      .commit_en   (commit_en),
      .ack_en      (ack_en),
      .guard_set   (guard_set)
   );

   // behavioural reference: flag sets on a qualifying strobe, never clears
   always @(posedge clk) begin
      if (rst_n && prog_strobe && ctrl_code == 4'b0110 && !rd_sel && !prot_pin)
         mflag <= 1'b1;
   end

   function automatic bit exp_commit();
      if (!rst_n) return 1'b0;
      if (ctrl_code != 4'b1010 || rd_sel || prot_pin) return 1'b0;
      if (mflag && tgt_addr < 8'h80) return 1'b0;
      return 1'b1;
   endfunction

   function automatic bit exp_ack();
      if (!rst_n) return 1'b0;
      if (ctrl_code == 4'b1010) return 1'b1;
      if (ctrl_code == 4'b0110) return !mflag;
      return 1'b0;
   endfunction

   task automatic check(input string tag, input string what, input bit act, input bit exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0b expected=%0b (pin=%0b code=%h rd=%0b addr=%h)",
                  tag, what, act, exp, prot_pin, ctrl_code, rd_sel, tgt_addr);
      end
   endtask

   task automatic drive(input bit pin, input logic [3:0] code, input bit rd,
                        input logic [7:0] addr, input bit stb, input string tag);
      @(negedge clk);
      prot_pin    = pin;
      ctrl_code   = code;
      rd_sel      = rd;
      tgt_addr    = addr;
      prog_strobe = stb;
      #1;
      check(tag, "commit_en", commit_en, exp_commit());
      check(tag, "ack_en", ack_en, exp_ack());
      check(tag, "guard_set", guard_set, mflag);
   endtask

   initial begin
      #(5.0 * 20000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: outputs quiet in reset
      drive(0, 4'b1010, 0, 8'h90, 0, "R1");
      drive(0, 4'b0110, 1, 8'h10, 0, "R1");
      @(negedge clk);
      rst_n = 1'b1;

      // R4: open array while pin low and flag clear
      for (int a = 0; a < 256; a += 17) drive(0, 4'b1010, 0, 8'(a), 0, "R4");
      drive(0, 4'b1010, 0, 8'h7F, 0, "R4");
      drive(0, 4'b1010, 0, 8'h80, 0, "R4");
      // R5: reads and foreign codes never commit
      drive(0, 4'b1010, 1, 8'h80, 0, "R5");
      drive(0, 4'b0101, 0, 8'h80, 0, "R5");
      drive(0, 4'b0110, 0, 8'hC0, 0, "R5");
      // R2 / R6: pin blocks all, array still acked
      for (int a = 0; a < 256; a += 51) drive(1, 4'b1010, 0, 8'(a), 0, "R2");
      drive(1, 4'b1010, 1, 8'h22, 0, "R6");
      // R7: guard code acked while clear, foreign code not
      drive(0, 4'b0110, 1, 8'h00, 0, "R7");
      drive(1, 4'b0110, 0, 8'h00, 0, "R7");
      drive(0, 4'b1111, 0, 8'h00, 0, "R7");
      // R9: none of these sets the flag
      drive(1, 4'b0110, 0, 8'h05, 1, "R9");
      drive(0, 4'b0110, 1, 8'h05, 1, "R9");
      drive(0, 4'b1010, 0, 8'h05, 1, "R9");
      drive(0, 4'b0110, 0, 8'h05, 0, "R9");
      drive(0, 4'b0110, 0, 8'h05, 0, "R9");
      // R8: qualifying strobe, arbitrary address
      drive(0, 4'b0110, 0, 8'h33, 1, "R8");
      drive(0, 4'b1010, 0, 8'h00, 0, "R8");
      // R3 / R6: lower half refused, upper half open, all acked
      drive(0, 4'b1010, 0, 8'h00, 0, "R3");
      drive(0, 4'b1010, 0, 8'h7F, 0, "R3");
      drive(0, 4'b1010, 0, 8'h80, 0, "R3");
      drive(0, 4'b1010, 0, 8'hFF, 0, "R3");
      for (int a = 3; a < 256; a += 29) drive(0, 4'b1010, 0, 8'(a), 0, "R6");
      // R2 with flag set
      drive(1, 4'b1010, 0, 8'hFF, 0, "R2");
      drive(1, 4'b1010, 0, 8'h10, 0, "R2");
      // R7: guard code refused once set
      drive(0, 4'b0110, 0, 8'h00, 0, "R7");
      drive(0, 4'b0110, 1, 8'h00, 1, "R7");
      // R10: reset leaves the flag set
      @(negedge clk);
      rst_n = 1'b0;
      drive(0, 4'b1010, 0, 8'h90, 0, "R10");
      drive(0, 4'b1010, 0, 8'h90, 0, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      drive(0, 4'b1010, 0, 8'h10, 0, "R10");
      drive(0, 4'b1010, 0, 8'hA0, 0, "R10");
      drive(0, 4'b0110, 1, 8'h00, 0, "R10");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule